// File: doc/BRIEF.md
# Auto-retransmit transmit transaction controller

This block sequences one complete transmit transaction for a low-rate packet radio that retries on its own. A transaction begins with a one-cycle strobe on a dedicated pin or with a start command from the register interface. Each attempt first asks an external channel-sensing unit whether the air is clear. A busy verdict is retried up to a programmed count. Once the channel is clear, the block requests transmission of the frame held in the transmit buffer. While the buffer content streams out, it looks at the ack-request flag of the first octet.

When an acknowledgement is requested, the block turns the receiver on and waits a fixed number of symbol periods. The symbol periods are measured by a prescaler on the system clock. If the wait expires, the whole attempt, channel sensing included, starts over until a frame-retry count is used up. Every outcome ends with a single one-cycle completion interrupt and a 3-bit status code. The status is held at 7 while the transaction runs. The backoff timing, the modulator and the demodulator are outside the block and are reached through simple request and done handshakes.

Top module: `aret_tx_ctrl`

## Requirements
- R1: While idle, a high level on `start_pin` or `start_cmd` at a clock edge starts a transaction. From the next cycle until completion, `txn_status` reads 7. After reset, `txn_status` is 0 and `irq_end`, `cca_req`, `tx_req` and `rx_en` are low.
- R2: `cca_req` is held high until a `cca_done` pulse arrives. On `cca_done` with `cca_idle` low, the block makes a fresh attempt. Each frame attempt makes at most `max_cca_retries`+1 channel checks. If all of them are busy, the transaction ends with status 3 and no transmit request.
- R3: After a clear channel, `tx_req` is held high until `tx_done`. The ack request is taken from `tx_octet_ackbit` on the first cycle in which `tx_octet_valid` is high. That bit is bit 5 of the first frame octet. The bit on later octets has no effect.
- R4: A frame whose ack bit is 0 completes with status 0 on `tx_done`, and `rx_en` is never raised.
- R5: A frame whose ack bit is 1 raises `rx_en` in the cycle after `tx_done`. Without an acknowledgement, `rx_en` stays high for exactly ACK_WAIT_SYM×CYC_PER_SYM cycles. An acknowledgement that arrives in the last of those cycles is still accepted.
- R6: A valid frame with `rx_is_ack` high ends the transaction. The status is 0 if `rx_frame_pending` is 0 and 1 if it is 1. A frame with `rx_is_ack` low is discarded and has no effect.
- R7: When the acknowledgement wait expires, the block starts a new attempt from channel sensing. After `max_frame_retries`+1 attempts without an acknowledgement, it ends with status 5.
- R8: `irq_end` is a single-cycle pulse in the cycle after the completing event, with `txn_status` already holding the final code. It occurs exactly once per transaction.
- R9: The retry limits are latched at start, and later changes to them have no effect on the running transaction. A start request while a transaction is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pin | input | 1 | Transmit strobe from the external pin |
| start_cmd | input | 1 | Start command from the register interface |
| max_cca_retries | input | CCA_W | Channel-check retry limit |
| max_frame_retries | input | FRM_W | Frame retransmission limit |
| cca_req | output | 1 | Channel-check request |
| cca_done | input | 1 | Channel-check result strobe |
| cca_idle | input | 1 | Result of the check: 1 means the channel is clear |
| tx_req | output | 1 | Transmit request |
| tx_octet_valid | input | 1 | An octet is being sent this cycle |
| tx_octet_ackbit | input | 1 | Bit 5 of the octet being sent |
| tx_done | input | 1 | End of transmission strobe |
| rx_en | output | 1 | Receiver on, waiting for an acknowledgement |
| rx_frame_valid | input | 1 | A valid frame was received |
| rx_is_ack | input | 1 | The received frame is an acknowledgement |
| rx_frame_pending | input | 1 | Frame-pending flag of the received acknowledgement |
| irq_end | output | 1 | Transaction-end interrupt pulse |
| txn_status | output | 3 | Result code: 0 ok, 1 ok with pending data, 3 channel busy, 5 no ack, 7 busy |

## Verification
The status reads 7 one cycle after the start strobe. The interrupt and its final code appear in the cycle after the handshake that ends the transaction: `cca_done`, `tx_done`, the acknowledgement, or the last wait cycle. The receive window must last exactly ACK_WAIT_SYM×CYC_PER_SYM cycles. The bench drives all stimulus and samples all outputs on falling edges, so each result is read a half period after the rising edge that produced it. The peripheral models count the cycles of each receive window and compare the count with the expected length. The scoreboard pairs each interrupt with the code expected for that transaction, and a later stray interrupt finds an empty queue.

// File: rtl/aret_tx_ctrl.sv
module aret_tx_ctrl #(
  parameter int CYC_PER_SYM  = 4,
  parameter int ACK_WAIT_SYM = 54,
  parameter int CCA_W        = 3,
  parameter int FRM_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pin,
  input  logic             start_cmd,
  input  logic [CCA_W-1:0] max_cca_retries,
  input  logic [FRM_W-1:0] max_frame_retries,
  output logic             cca_req,
  input  logic             cca_done,
  input  logic             cca_idle,
  output logic             tx_req,
  input  logic             tx_octet_valid,
  input  logic             tx_octet_ackbit,
  input  logic             tx_done,
  output logic             rx_en,
  input  logic             rx_frame_valid,
  input  logic             rx_is_ack,
  input  logic             rx_frame_pending,
  output logic             irq_end,
  output logic [2:0]       txn_status
);
  localparam int PW = $clog2(CYC_PER_SYM + 1);
  localparam int SW = $clog2(ACK_WAIT_SYM + 1);
  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_PENDING = 3'd1;
  localparam logic [2:0] ST_CH_FAIL = 3'd3;
  localparam logic [2:0] ST_NO_ACK  = 3'd5;
  localparam logic [2:0] ST_BUSY    = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_CCA, S_TX, S_ACK} state_t;

  state_t           st;
  logic [CCA_W-1:0] cca_lim, cca_cnt;
  logic [FRM_W-1:0] frm_lim, frm_cnt;
  logic [PW-1:0]    pre;
  logic [SW-1:0]    sym;
  logic             first_seen, ack_req;
  logic             ack_now, last_tick, got_ack;

  assign cca_req   = (st == S_CCA);
  assign tx_req    = (st == S_TX);
  assign rx_en     = (st == S_ACK);
  assign ack_now   = first_seen ? ack_req : (tx_octet_valid & tx_octet_ackbit);
  assign last_tick = (pre == PW'(CYC_PER_SYM - 1)) && (sym == SW'(ACK_WAIT_SYM - 1));
  assign got_ack   = rx_frame_valid & rx_is_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cca_lim    <= '0;
      cca_cnt    <= '0;
      frm_lim    <= '0;
      frm_cnt    <= '0;
      pre        <= '0;
      sym        <= '0;
      first_seen <= 1'b0;
      ack_req    <= 1'b0;
      irq_end    <= 1'b0;
      txn_status <= ST_OK;
    end else begin
      irq_end <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_pin || start_cmd) begin
            st         <= S_CCA;
            cca_lim    <= max_cca_retries;
            frm_lim    <= max_frame_retries;
            cca_cnt    <= '0;
            frm_cnt    <= '0;
            txn_status <= ST_BUSY;
          end
        end
        S_CCA: begin
          if (cca_done) begin
            if (cca_idle) begin
              st         <= S_TX;
              first_seen <= 1'b0;
              ack_req    <= 1'b0;
            end else if (cca_cnt == cca_lim) begin
              st         <= S_IDLE;
              irq_end    <= 1'b1;
              txn_status <= ST_CH_FAIL;
            end else begin
              cca_cnt <= cca_cnt + CCA_W'(1);
            end
          end
        end
        S_TX: begin
          if (tx_octet_valid && !first_seen) begin
            first_seen <= 1'b1;
            ack_req    <= tx_octet_ackbit;
          end
          if (tx_done) begin
            if (ack_now) begin
              st  <= S_ACK;
              pre <= '0;
              sym <= '0;
            end else begin
              st         <= S_IDLE;
              irq_end    <= 1'b1;
              txn_status <= ST_OK;
            end
          end
        end
        S_ACK: begin
          if (got_ack) begin
            st         <= S_IDLE;
            irq_end    <= 1'b1;
            txn_status <= rx_frame_pending ? ST_PENDING : ST_OK;
          end else if (last_tick) begin
            if (frm_cnt == frm_lim) begin
              st         <= S_IDLE;
              irq_end    <= 1'b1;
              txn_status <= ST_NO_ACK;
            end else begin
              st      <= S_CCA;
              frm_cnt <= frm_cnt + FRM_W'(1);
              cca_cnt <= '0;
            end
          end else if (pre == PW'(CYC_PER_SYM - 1)) begin
            pre <= '0;
            sym <= sym + SW'(1);
          end else begin
            pre <= pre + PW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aret_tx_ctrl_chk.sv
module aret_tx_ctrl_chk #(
  parameter int LIMIT = 216
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pin,
  input logic       start_cmd,
  input logic       cca_req,
  input logic       tx_req,
  input logic       rx_en,
  input logic       rx_frame_valid,
  input logic       rx_is_ack,
  input logic       rx_frame_pending,
  input logic       irq_end,
  input logic [2:0] txn_status
);
  int unsigned win;

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) win <= 0;
    else                  win <= win + 1;
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_status != 3'd7 && (start_pin || start_cmd)) |=> txn_status == 3'd7);

  p_chfail_no_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_end && txn_status == 3'd3) |-> $past(cca_req));

  p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cca_req, tx_req, rx_en}));

  p_rx_after_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en) |-> $past(tx_req));

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> win < LIMIT);

  p_ack_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_frame_valid && rx_is_ack && !rx_frame_pending) |=> (irq_end && txn_status == 3'd0));

  p_ack_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_frame_valid && rx_is_ack && rx_frame_pending) |=> (irq_end && txn_status == 3'd1));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |=> !irq_end);

  p_irq_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> (txn_status != 3'd7 && !cca_req && !tx_req && !rx_en));
endmodule

bind aret_tx_ctrl aret_tx_ctrl_chk #(.LIMIT(CYC_PER_SYM * ACK_WAIT_SYM)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .start_cmd(start_cmd),
  .cca_req(cca_req), .tx_req(tx_req), .rx_en(rx_en),
  .rx_frame_valid(rx_frame_valid), .rx_is_ack(rx_is_ack),
  .rx_frame_pending(rx_frame_pending), .irq_end(irq_end), .txn_status(txn_status)
);

// File: tb/aret_tx_ctrl_bench.sv
module aret_tx_ctrl_bench;
  localparam int CPS   = 4;
  localparam int NSYM  = 54;
  localparam int LIMIT = CPS * NSYM;

  logic clk = 0, rst_n = 0;
  logic start_pin = 0, start_cmd = 0;
  logic [2:0] max_cca = 0;
  logic [3:0] max_frm = 0;
  logic cca_req, cca_done = 0, cca_idle = 0;
  logic tx_req, tx_octet_valid = 0, tx_octet_ackbit = 0, tx_done = 0;
  logic rx_en, rx_frame_valid = 0, rx_is_ack = 0, rx_frame_pending = 0;
  logic irq_end;
  logic [2:0] txn_status;

  aret_tx_ctrl #(.CYC_PER_SYM(CPS), .ACK_WAIT_SYM(NSYM)) u_aret_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .start_cmd(start_cmd),
    .max_cca_retries(max_cca), .max_frame_retries(max_frm),
    .cca_req(cca_req), .cca_done(cca_done), .cca_idle(cca_idle),
    .tx_req(tx_req), .tx_octet_valid(tx_octet_valid), .tx_octet_ackbit(tx_octet_ackbit),
    .tx_done(tx_done), .rx_en(rx_en), .rx_frame_valid(rx_frame_valid),
    .rx_is_ack(rx_is_ack), .rx_frame_pending(rx_frame_pending),
    .irq_end(irq_end), .txn_status(txn_status)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int exp_q[$];
  string tag_q[$];
  int irq_count = 0;

  int busy_left = 0; bit always_busy = 0; int cca_dly = 0; int cca_pulses = 0;
  bit fcf_bit = 0; int tx_ph = 0; int tx_count = 0;
  int plan[8]; int ack_at = 5; int win = 0; int attempts = 0; bit acked = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cca_done) begin
      cca_done = 0; cca_dly = 0;
    end else if (cca_req) begin
      cca_dly++;
      if (cca_dly == 2) begin
        cca_done = 1;
        cca_idle = !(always_busy || busy_left > 0);
        if (busy_left > 0) busy_left--;
        cca_pulses++;
      end
    end else cca_dly = 0;
  end

  always @(negedge clk) begin
    tx_octet_valid = 0; tx_done = 0;
    if (tx_req) begin
      tx_ph++;
      if (tx_ph == 1) begin tx_octet_valid = 1; tx_octet_ackbit = fcf_bit; tx_count++; end
      else if (tx_ph == 2) begin tx_octet_valid = 1; tx_octet_ackbit = 1; end
      else if (tx_ph == 3) tx_done = 1;
    end else tx_ph = 0;
  end

  always @(negedge clk) begin
    rx_frame_valid = 0; rx_is_ack = 0; rx_frame_pending = 0;
    if (rx_en) begin
      win++;
      if (win == 1) begin attempts++; acked = 0; end
      case (plan[(attempts - 1) % 8])
        1: if (win == ack_at) begin rx_frame_valid = 1; rx_is_ack = 1; acked = 1; end
        2: if (win == ack_at) begin rx_frame_valid = 1; rx_is_ack = 1; rx_frame_pending = 1; acked = 1; end
        3: if (win == ack_at) begin rx_frame_valid = 1; rx_frame_pending = 1; end
        4: if (win == LIMIT) begin rx_frame_valid = 1; rx_is_ack = 1; acked = 1; end
        default: ;
      endcase
    end else if (win > 0) begin
      if (!acked) chk(win == LIMIT, "R5 ack wait window length", win, LIMIT);
      win = 0;
    end
  end

  always @(negedge clk) begin
    if (irq_end) begin
      irq_count++;
      if (exp_q.size() == 0) chk(0, "R9 R8 unexpected completion interrupt", 1, 0);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(txn_status == 3'(e), t, txn_status, e);
      end
    end
  end

  task automatic txn(input bit use_pin, input int cca_lim, input int frm_lim,
                     input int exp, input string tag,
                     input int exp_cca, input int exp_tx, input int exp_att, input bit poke);
    automatic int base = irq_count;
    automatic int n = 0;
    max_cca = 3'(cca_lim); max_frm = 4'(frm_lim);
    cca_pulses = 0; tx_count = 0; attempts = 0;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    if (use_pin) start_pin = 1; else start_cmd = 1;
    @(negedge clk);
    start_pin = 0; start_cmd = 0;
    chk(txn_status == 3'd7, "R1 status busy after start", txn_status, 7);
    if (poke) begin
      repeat (10) @(negedge clk);
      max_frm = 4'd5; max_cca = 3'd0;
      start_cmd = 1; @(negedge clk); start_cmd = 0;
      start_pin = 1; @(negedge clk); start_pin = 0;
    end
    while (irq_count == base && n < 20000) begin @(negedge clk); n++; end
    chk(irq_count == base + 1, "R8 one interrupt per transaction", irq_count - base, 1);
    repeat (20) @(negedge clk);
    chk(irq_count == base + 1, "R8 R9 no further interrupt", irq_count - base, 1);
    chk(cca_pulses == exp_cca, "R2 channel checks", cca_pulses, exp_cca);
    chk(tx_count == exp_tx, "R3 transmissions", tx_count, exp_tx);
    chk(attempts == exp_att, "R7 receive windows", attempts, exp_att);
  endtask

  initial begin
    foreach (plan[i]) plan[i] = 0;
    repeat (3) @(negedge clk);
    chk(txn_status == 3'd0 && !irq_end && !cca_req && !tx_req && !rx_en,
        "R1 reset state", txn_status, 0);
    rst_n = 1;
    @(negedge clk);

    fcf_bit = 0;
    txn(1, 0, 0, 0, "R4 no ack request, status ok", 1, 1, 0, 0);

    fcf_bit = 1; plan[0] = 1; ack_at = 5;
    txn(0, 0, 0, 0, "R6 ack without pending", 1, 1, 1, 0);

    plan[0] = 2; ack_at = 1;
    txn(1, 0, 0, 1, "R6 ack with pending", 1, 1, 1, 0);

    fcf_bit = 0; busy_left = 2;
    txn(0, 3, 0, 0, "R2 busy twice then clear", 3, 1, 0, 0);

    always_busy = 1;
    txn(0, 2, 0, 3, "R2 channel access failure", 3, 0, 0, 0);
    txn(1, 0, 3, 3, "R2 zero retries failure", 1, 0, 0, 0);
    always_busy = 0;

    fcf_bit = 1; plan[0] = 0; plan[1] = 0; plan[2] = 0;
    txn(0, 0, 2, 5, "R7 no ack after retries", 3, 3, 3, 0);
    txn(0, 0, 0, 5, "R7 zero frame retries", 1, 1, 1, 0);

    plan[0] = 3; plan[1] = 1; ack_at = 7;
    txn(1, 1, 3, 0, "R6 non-ack frame discarded then ack", 2, 2, 2, 0);

    plan[0] = 4;
    txn(0, 0, 0, 0, "R5 ack on last window cycle", 1, 1, 1, 0);

    plan[0] = 0; plan[1] = 0;
    txn(0, 0, 1, 5, "R9 limits latched, restart ignored", 2, 2, 2, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule